// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the word address for a pipelined burst memory. When an access opens, it captures a full address from the address bus. It then walks the two lowest address bits through a four-beat pattern while the upper bits stay fixed. Each step happens on a clock edge where the advance input is asserted. When advance is deasserted, the sequence pauses on the current beat and the address stays put.

Two address strobes can open an access. The controller strobe acts alone. The processor strobe acts only while chip enable is asserted.

A static order select chooses between two beat patterns:
- Linear: the low bits count upward modulo four from the start value.
- Interleaved: the low bits are the start value XOR the beat index.

The output is formed from the captured start address and a two-bit beat index. The captured address itself is never modified.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe, `seq_addr` is all zeros.
- R2: A rising edge with `ctl_stb_n` low captures `bus_addr`, whatever the state of `ce_n`. `seq_addr` equals `bus_addr` after that edge.
- R3: A rising edge with `cpu_stb_n` low and `ce_n` low captures `bus_addr`.
- R4: `cpu_stb_n` low while `ce_n` is high does not capture an address. Only the advance input then acts on `seq_addr`.
- R5: Without a capture, an edge with `step_n` low moves to the next beat. An edge with `step_n` high leaves `seq_addr` unchanged.
- R6: Bits `ADDR_W-1` down to 2 of `seq_addr` keep the captured value for the whole burst.
- R7: With `order_ilv` = 0 (linear), bits [1:0] on beat n are (start + n) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R8: With `order_ilv` = 1 (interleaved), bits [1:0] on beat n are start XOR n. For example, start 01 gives 01, 00, 11, 10.
- R9: After the fourth beat, the next advance returns bits [1:0] to the start value, and the pattern repeats.
- R10: A capture on the same edge as an advance wins: the beat index restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address offered at access start |
| ctl_stb_n | input | 1 | Controller address strobe, active low, ungated |
| cpu_stb_n | input | 1 | Processor address strobe, active low, gated by `ce_n` |
| ce_n | input | 1 | Chip enable, active low, qualifies `cpu_stb_n` |
| step_n | input | 1 | Advance strobe, active low |
| order_ilv | input | 1 | Beat order: 1 interleaved, 0 linear; held static |
| seq_addr | output | ADDR_W | Current burst address |

## Verification
Some behaviours are checked by the embedded assertions on every cycle:
- the beat index clears on capture and increments by one on each advance;
- the beat index and captured address hold when idle;
- the gated processor strobe cannot cause a capture;
- each wrap returns to the start bits.

Other behaviours only the bench scenarios can show. These are the exact linear and interleaved beat values for given start addresses, and the full address after mixed strobe patterns. The bench predicts each one from an independent model and compares it through a scoreboard.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } beat_order_e;

  // Low address bits for beat index n, given the captured start bits.
  function automatic logic [BEAT_W-1:0] beat_low_bits(
    input logic [BEAT_W-1:0] start_bits,
    input logic [BEAT_W-1:0] beat_idx,
    input beat_order_e       order
  );
    logic [BEAT_W-1:0] res;
    if (order == ORD_INTERLEAVE) res = start_bits ^ beat_idx;
    else                         res = start_bits + beat_idx;
    return res;
  endfunction

  function automatic logic [BEAT_W-1:0] beat_next(input logic [BEAT_W-1:0] beat_idx);
    return beat_idx + {{(BEAT_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/bsq_strobe_decode.sv
module bsq_strobe_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_stb_n,
  input  logic cpu_stb_n,
  input  logic ce_n,
  input  logic step_n,
  output logic load_evt,
  output logic step_evt
);
  logic cpu_load;

  assign cpu_load = ~cpu_stb_n & ~ce_n;
  assign load_evt = ~ctl_stb_n | cpu_load;
  // capture outranks advance
  assign step_evt = ~load_evt & ~step_n;

  // R10
  load_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_evt && step_evt));

  // R2
  ctl_always_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_stb_n |-> load_evt);
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (load_evt) q <= d;
  end

  // R6
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(q));

  // R2
  base_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> q == $past(d));
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              step_evt,
  output logic [BEAT_W-1:0] beat_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)        beat_idx <= '0;
    else if (load_evt) beat_idx <= '0;
    else if (step_evt) beat_idx <= beat_next(beat_idx);
  end

  // R10
  load_clears_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> beat_idx == '0);

  // R5
  step_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> beat_idx == $past(beat_idx) + 2'd1);

  // R5
  idle_holds_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_evt) |=> $stable(beat_idx));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ctl_stb_n,
  input  logic              cpu_stb_n,
  input  logic              ce_n,
  input  logic              step_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] seq_addr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              load_evt;
  logic              step_evt;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_idx;
  logic [BEAT_W-1:0] low_bits;
  beat_order_e       order;

  assign order = beat_order_e'(order_ilv);

  bsq_strobe_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_stb_n (ctl_stb_n),
    .cpu_stb_n (cpu_stb_n),
    .ce_n      (ce_n),
    .step_n    (step_n),
    .load_evt  (load_evt),
    .step_evt  (step_evt)
  );

  bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .d        (bus_addr),
    .q        (base_q)
  );

  bsq_beat_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .beat_idx (beat_idx)
  );

  assign low_bits = beat_low_bits(base_q[BEAT_W-1:0], beat_idx, order);

  generate
    if (UPPER_W > 0) begin : g_upper
      assign seq_addr = {base_q[ADDR_W-1:BEAT_W], low_bits};
    end else begin : g_low_only
      assign seq_addr = low_bits[ADDR_W-1:0];
    end
  endgenerate

  // R4
  gated_cpu_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stb_n && ce_n) |-> !load_evt);

  // R9
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && beat_idx == 2'd3) |=> seq_addr[1:0] == base_q[1:0]);

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && step_n) |=> $stable(seq_addr));
endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          ctl_stb_n = 1'b1, cpu_stb_n = 1'b1, ce_n = 1'b1, step_n = 1'b1;
  logic          order_ilv = 1'b0;
  logic [AW-1:0] seq_addr;

  int n_chk = 0, n_fail = 0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .ctl_stb_n(ctl_stb_n), .cpu_stb_n(cpu_stb_n), .ce_n(ce_n),
    .step_n(step_n), .order_ilv(order_ilv), .seq_addr(seq_addr)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    if (order_ilv) lo = m_base[1:0] ^ 2'(m_beat);
    else           lo = 2'((int'(m_base[1:0]) + m_beat) % 4);
    return {m_base[AW-1:2], lo};
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic drive(input logic c_n, input logic p_n, input logic e_n,
                       input logic s_n, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    ctl_stb_n = c_n; cpu_stb_n = p_n; ce_n = e_n; step_n = s_n; bus_addr = a;
    if (!c_n || (!p_n && !e_n)) begin
      m_base = a; m_beat = 0;
    end else if (!s_n) begin
      m_beat = (m_beat + 1) % 4;
    end
    exp_q.push_back(model_addr());
    tag_q.push_back(tag);
  endtask

  // Monitor: compares one result per clock, away from the edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (seq_addr !== e) begin
        n_fail++;
        $display("FAIL %s: seq_addr=%h expected=%h", t, seq_addr, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (seq_addr !== '0) begin
      n_fail++;
      $display("FAIL R1: seq_addr=%h expected=0", seq_addr);
    end
    @(negedge clk); rst_n = 1'b1;
    drive(1, 1, 1, 1, 18'h15555, "R1 idle after reset");

    // Linear order, controller strobe (chip enable high on purpose)
    order_ilv = 1'b0;
    drive(0, 1, 1, 1, 18'h2A5D1, "R2 ctl load");
    drive(1, 1, 1, 0, 18'h00000, "R7 linear beat1");
    drive(1, 1, 1, 1, 18'h3FFFF, "R5 hold");
    drive(1, 1, 1, 0, 18'h3FFFF, "R7 linear beat2");
    drive(1, 1, 1, 0, 18'h00000, "R7 linear beat3");
    drive(1, 1, 1, 0, 18'h00000, "R9 linear wrap");
    drive(1, 1, 1, 0, 18'h00000, "R6 upper kept");

    // Processor strobe with chip enable
    drive(1, 0, 0, 1, 18'h1C7F2, "R3 cpu load");
    drive(1, 1, 0, 0, 18'h00000, "R7 linear from 10");
    // Gated processor strobe: nothing changes, then advance still acts
    drive(1, 0, 1, 1, 18'h0000F, "R4 gated no load");
    drive(1, 0, 1, 0, 18'h0000F, "R4 gated advance only");

    // Capture beats advance
    drive(0, 1, 1, 0, 18'h0ABC3, "R10 load over advance");
    drive(1, 0, 0, 0, 18'h31110, "R10 cpu load over advance");

    // Interleaved order
    order_ilv = 1'b1;
    drive(0, 1, 0, 1, 18'h24681, "R8 ilv load");
    drive(1, 1, 1, 0, 18'h00000, "R8 ilv beat1");
    drive(1, 1, 1, 0, 18'h00000, "R8 ilv beat2");
    drive(1, 1, 1, 1, 18'h00000, "R5 ilv hold");
    drive(1, 1, 1, 0, 18'h00000, "R8 ilv beat3");
    drive(1, 1, 1, 0, 18'h00000, "R9 ilv wrap");
    drive(0, 1, 1, 1, 18'h3FFFE, "R2 ilv load 10");
    for (int i = 0; i < 5; i++) drive(1, 1, 1, 0, 18'h0, "R8 ilv from 10");

    // Reset returns to zero
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    n_chk++;
    if (seq_addr !== '0) begin
      n_fail++;
      $display("FAIL R1: seq_addr=%h expected=0 after reset", seq_addr);
    end

    repeat (2) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule